// File: doc/BRIEF.md
# Multi-Way Sequential Stream Prefetcher

This block sits between a first-level cache and the next, pipelined, level of memory. It holds several small FIFO prefetch buffers, each following its own run of consecutive cache lines. When the cache misses, it presents the missing line address on the lookup port. The block compares that address against the oldest entry of every buffer. When the address matches and that entry's data has arrived, the line is handed straight back. The FIFO then moves forward and requests one more sequential line. When no buffer's oldest entry matches, the block reports a miss. It then takes the least recently used buffer, wipes it, and starts a new stream at the following lines.

Prefetched lines live only inside the buffers. The cache receives a line only when it looks that line up. The block sends requests back to back over a valid/ready request port and does not wait for earlier responses, so many requests can be outstanding at once. Responses may return in any order. Each one carries the tag of its request, and the tag names the buffer, the slot and the generation of that buffer. A response whose generation is out of date, because its buffer was reallocated in the meantime, is dropped.

Top module: `seqstream_prefetcher`

## Requirements
- R1: After reset every buffer is empty: `req_valid` stays low, and the first lookup completes as a miss (`miss_done`=1, `miss_hit`=0).
- R2: A lookup whose line address matches no buffer's oldest entry completes in the same cycle as a miss. The least recently used buffer is then refilled with lines address+1 up to address+DEPTH, and requests for those lines leave in increasing address order.
- R3: Requests are issued on consecutive cycles while `req_ready` is high, without waiting for responses. While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_tag` hold steady.
- R4: `req_tag` is {generation, buffer, slot}. The slot sits in the low `$clog2(DEPTH)` bits, and above it the buffer index in `$clog2(NUM_BUF)` bits. The top GEN_W bits hold a per-buffer generation that starts at 0 and goes up by one on every allocation. After an allocation at address A, line A+1+k uses slot k. A line appended later takes the slot of the entry that was just removed, so line L of that stream always sits in slot (L−A−1) mod DEPTH.
- R5: A lookup that matches a buffer's oldest entry, with that entry's data present, completes in the same cycle with `miss_hit`=1 and `miss_data` equal to the response data for that line. That buffer then requests the next line of its stream.
- R6: A lookup that matches an oldest entry whose data has not arrived does not complete until the response for that entry has been taken in.
- R7: Only the oldest entry of each buffer is compared. A lookup that matches a younger entry completes as a miss and reallocates a buffer.
- R8: Buffers are chosen for reallocation in least-recently-used order, where both hits and allocations count as uses. At reset the order runs from buffer 0 (first to be replaced) up to buffer NUM_BUF−1.
- R9: A response whose generation field differs from its buffer's current generation changes no entry. Lines later returned from a reallocated buffer carry only the data of the new stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Lookup request, held until `miss_done` |
| miss_addr | input | LA_W | Line address of the cache miss |
| miss_done | output | 1 | Lookup completes this cycle |
| miss_hit | output | 1 | Completed lookup found its line |
| miss_data | output | DATA_W | Line data, valid with `miss_hit` |
| req_valid | output | 1 | Prefetch request valid |
| req_ready | input | 1 | Next level accepts the request |
| req_addr | output | LA_W | Line address to fetch |
| req_tag | output | GEN_W+log2(NUM_BUF)+log2(DEPTH) | Request tag {generation, buffer, slot} |
| rsp_valid | input | 1 | Response data present |
| rsp_tag | input | GEN_W+log2(NUM_BUF)+log2(DEPTH) | Tag copied from the request |
| rsp_data | input | DATA_W | Line data |

## Verification
The bound checker watches several properties on every cycle:
- the request port holds steady under back-pressure;
- a lookup never completes while it is stalled on a pending line, and never completes unless a lookup is asking;
- no request appears while no buffer is allocated;
- the tag's buffer field stays in range;
- exactly one buffer is marked as the replacement victim.

Other properties can only be shown by the bench's scenarios, which track each stream's expected addresses and replacement order:
- the exact prefetch address sequence and slot numbering;
- the returned data;
- the LRU choice among interleaved streams;
- the dropping of responses that arrive after their buffer was reused.

// File: rtl/sbpf_pkg.sv
package sbpf_pkg;
  // Life cycle of one prefetch slot
  typedef enum logic [1:0] {
    SL_IDLE     = 2'd0,  // no line assigned
    SL_QUEUED   = 2'd1,  // line address known, request not yet sent
    SL_INFLIGHT = 2'd2,  // request sent, waiting for data
    SL_FILLED   = 2'd3   // data present
  } slot_st_e;
endpackage

// File: rtl/sbpf_way.sv
module sbpf_way
  import sbpf_pkg::*;
#(
  parameter int LA_W   = 32,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4,
  parameter int GEN_W  = 2,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LA_W-1:0]   lk_addr,
  input  logic              alloc_en,
  input  logic              pop_en,
  input  logic              iss_en,
  input  logic              fill_en,
  input  logic [SLOT_W-1:0] fill_slot,
  input  logic [GEN_W-1:0]  fill_gen,
  input  logic [DATA_W-1:0] fill_data,
  output logic              vld,
  output logic              head_match,
  output logic              head_ready,
  output logic [DATA_W-1:0] head_data,
  output logic              pend,
  output logic [SLOT_W-1:0] pend_slot,
  output logic [LA_W-1:0]   pend_addr,
  output logic [GEN_W-1:0]  gen
);
  slot_st_e          st_q [DEPTH];
  slot_st_e          st_d [DEPTH];
  logic [LA_W-1:0]   ad_q [DEPTH];
  logic [LA_W-1:0]   ad_d [DEPTH];
  logic [DATA_W-1:0] dt_q [DEPTH];
  logic [DEPTH-1:0]  dt_we;
  logic [SLOT_W-1:0] hd_q, hd_d, hd_next, hd_prev;
  logic [GEN_W-1:0]  gen_q, gen_d;
  logic              vld_q, vld_d;
  logic              fill_ok;

  assign hd_next = (hd_q == SLOT_W'(DEPTH-1)) ? '0 : hd_q + 1'b1;
  assign hd_prev = (hd_q == '0) ? SLOT_W'(DEPTH-1) : hd_q - 1'b1;

  assign vld        = vld_q;
  assign gen        = gen_q;
  assign head_match = vld_q && (st_q[hd_q] != SL_IDLE) && (ad_q[hd_q] == lk_addr);
  assign head_ready = (st_q[hd_q] == SL_FILLED);
  assign head_data  = dt_q[hd_q];
  assign pend_addr  = ad_q[pend_slot];

  // A response is accepted only for the current generation and an in-flight slot
  assign fill_ok = fill_en && (fill_gen == gen_q) && (st_q[fill_slot] == SL_INFLIGHT);

  // Oldest queued slot, searched in FIFO order from the head
  always_comb begin
    int idx;
    pend      = 1'b0;
    pend_slot = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = int'(hd_q) + k;
      if (idx >= DEPTH) idx = idx - DEPTH;
      if (!pend && st_q[idx] == SL_QUEUED) begin
        pend      = 1'b1;
        pend_slot = SLOT_W'(idx);
      end
    end
  end

  always_comb begin
    for (int k = 0; k < DEPTH; k++) dt_we[k] = fill_ok && (fill_slot == SLOT_W'(k));
  end

  // Next state: fill, issue, advance, then reallocation overrides all
  always_comb begin
    st_d  = st_q;
    ad_d  = ad_q;
    hd_d  = hd_q;
    gen_d = gen_q;
    vld_d = vld_q;
    if (fill_ok) st_d[fill_slot] = SL_FILLED;
    if (iss_en)  st_d[pend_slot] = SL_INFLIGHT;
    if (pop_en) begin
      st_d[hd_q] = SL_QUEUED;
      ad_d[hd_q] = ad_q[hd_prev] + 1'b1;
      hd_d       = hd_next;
    end
    if (alloc_en) begin
      vld_d = 1'b1;
      gen_d = gen_q + 1'b1;
      hd_d  = '0;
      for (int k = 0; k < DEPTH; k++) begin
        st_d[k] = SL_QUEUED;
        ad_d[k] = lk_addr + LA_W'(k + 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) st_q[k] <= SL_IDLE;
      hd_q  <= '0;
      gen_q <= '0;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      hd_q  <= hd_d;
      gen_q <= gen_d;
      vld_q <= vld_d;
    end
  end

  // Address and data storage carry no reset; slot state qualifies them
  always_ff @(posedge clk) begin
    ad_q <= ad_d;
    for (int k = 0; k < DEPTH; k++) begin
      if (dt_we[k]) dt_q[k] <= fill_data;
    end
  end
endmodule

// File: rtl/sbpf_lru.sv
module sbpf_lru #(
  parameter int NB    = 4,
  parameter int BUF_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [BUF_W-1:0] touch_id,
  output logic [BUF_W-1:0] victim_id,
  output logic [NB-1:0]    victim_oh
);
  // Rank 0 = most recent, rank NB-1 = next victim
  logic [BUF_W-1:0] rk_q [NB];
  logic [BUF_W-1:0] rk_d [NB];
  logic [BUF_W-1:0] rk_t;

  assign rk_t = rk_q[touch_id];

  always_comb begin
    rk_d = rk_q;
    if (touch_en) begin
      for (int i = 0; i < NB; i++) begin
        if (BUF_W'(i) == touch_id) rk_d[i] = '0;
        else if (rk_q[i] < rk_t)   rk_d[i] = rk_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_id = '0;
    for (int i = 0; i < NB; i++) begin
      victim_oh[i] = (rk_q[i] == BUF_W'(NB-1));
      if (victim_oh[i]) victim_id = BUF_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) rk_q[i] <= BUF_W'(NB-1-i);
    end else begin
      rk_q <= rk_d;
    end
  end
endmodule

// File: rtl/sbpf_req_arb.sv
module sbpf_req_arb #(
  parameter int NB     = 4,
  parameter int BUF_W  = 2,
  parameter int SLOT_W = 2,
  parameter int GEN_W  = 2,
  parameter int LA_W   = 32,
  localparam int TAG_W = GEN_W + BUF_W + SLOT_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NB-1:0]              pend,
  input  logic [NB-1:0][SLOT_W-1:0]  pend_slot,
  input  logic [NB-1:0][LA_W-1:0]    pend_addr,
  input  logic [NB-1:0][GEN_W-1:0]   pend_gen,
  output logic [NB-1:0]              grant,
  output logic                       req_valid,
  input  logic                       req_ready,
  output logic [LA_W-1:0]            req_addr,
  output logic [TAG_W-1:0]           req_tag
);
  logic [BUF_W-1:0] rr_q, rr_d, pick;
  logic             any_p, load;
  logic             rv_q, rv_d;
  logic [LA_W-1:0]  ra_q, ra_d;
  logic [TAG_W-1:0] rt_q, rt_d;

  // Rotating priority starting at rr_q
  always_comb begin
    int idx;
    any_p = 1'b0;
    pick  = '0;
    for (int k = 0; k < NB; k++) begin
      idx = int'(rr_q) + k;
      if (idx >= NB) idx = idx - NB;
      if (!any_p && pend[idx]) begin
        any_p = 1'b1;
        pick  = BUF_W'(idx);
      end
    end
  end

  assign load = any_p && (!rv_q || req_ready);

  always_comb begin
    for (int i = 0; i < NB; i++) grant[i] = load && (pick == BUF_W'(i));
  end

  always_comb begin
    rv_d = rv_q;
    ra_d = ra_q;
    rt_d = rt_q;
    rr_d = rr_q;
    if (load) begin
      rv_d = 1'b1;
      ra_d = pend_addr[pick];
      rt_d = {pend_gen[pick], pick, pend_slot[pick]};
      rr_d = (pick == BUF_W'(NB-1)) ? '0 : pick + 1'b1;
    end else if (req_ready) begin
      rv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rr_q <= '0;
      ra_q <= '0;
      rt_q <= '0;
    end else begin
      rv_q <= rv_d;
      rr_q <= rr_d;
      ra_q <= ra_d;
      rt_q <= rt_d;
    end
  end

  assign req_valid = rv_q;
  assign req_addr  = ra_q;
  assign req_tag   = rt_q;
endmodule

// File: rtl/seqstream_prefetcher.sv
module seqstream_prefetcher #(
  parameter int NUM_BUF = 4,
  parameter int DEPTH   = 4,
  parameter int LA_W    = 32,
  parameter int DATA_W  = 64,
  parameter int GEN_W   = 2,
  localparam int BUF_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int TAG_W  = GEN_W + BUF_W + SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [LA_W-1:0]   miss_addr,
  output logic              miss_done,
  output logic              miss_hit,
  output logic [DATA_W-1:0] miss_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [LA_W-1:0]   req_addr,
  output logic [TAG_W-1:0]  req_tag,
  input  logic              rsp_valid,
  input  logic [TAG_W-1:0]  rsp_tag,
  input  logic [DATA_W-1:0] rsp_data
);
  logic [NUM_BUF-1:0]              way_vld, w_match, w_ready, w_pend;
  logic [NUM_BUF-1:0]              pop_en, alloc_en, fill_en, grant;
  logic [NUM_BUF-1:0][DATA_W-1:0]  w_data;
  logic [NUM_BUF-1:0][SLOT_W-1:0]  w_pslot;
  logic [NUM_BUF-1:0][LA_W-1:0]    w_paddr;
  logic [NUM_BUF-1:0][GEN_W-1:0]   w_gen;
  logic [NUM_BUF-1:0]              victim_oh;
  logic [BUF_W-1:0]                victim_id, m_id, touch_id;
  logic                            any_m, stall, touch_en;
  logic [SLOT_W-1:0]               r_slot;
  logic [BUF_W-1:0]                r_buf;
  logic [GEN_W-1:0]                r_gen;

  assign r_slot = rsp_tag[SLOT_W-1:0];
  assign r_buf  = rsp_tag[SLOT_W +: BUF_W];
  assign r_gen  = rsp_tag[TAG_W-1 -: GEN_W];

  // Lowest-index buffer whose oldest entry matches
  always_comb begin
    any_m = 1'b0;
    m_id  = '0;
    for (int b = NUM_BUF-1; b >= 0; b--) begin
      if (w_match[b]) begin
        any_m = 1'b1;
        m_id  = BUF_W'(b);
      end
    end
  end

  assign stall     = miss_valid && any_m && !w_ready[m_id];
  assign miss_hit  = miss_valid && any_m && w_ready[m_id];
  assign miss_done = miss_valid && (!any_m || w_ready[m_id]);
  assign miss_data = w_data[m_id];
  assign touch_en  = miss_done;
  assign touch_id  = any_m ? m_id : victim_id;

  genvar g;
  generate
    for (g = 0; g < NUM_BUF; g++) begin : g_way
      assign pop_en[g]   = miss_hit && (m_id == BUF_W'(g));
      assign alloc_en[g] = miss_done && !any_m && (victim_id == BUF_W'(g));
      assign fill_en[g]  = rsp_valid && (r_buf == BUF_W'(g));

      sbpf_way #(
        .LA_W(LA_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .GEN_W(GEN_W), .SLOT_W(SLOT_W)
      ) u_way (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_addr    (miss_addr),
        .alloc_en   (alloc_en[g]),
        .pop_en     (pop_en[g]),
        .iss_en     (grant[g]),
        .fill_en    (fill_en[g]),
        .fill_slot  (r_slot),
        .fill_gen   (r_gen),
        .fill_data  (rsp_data),
        .vld        (way_vld[g]),
        .head_match (w_match[g]),
        .head_ready (w_ready[g]),
        .head_data  (w_data[g]),
        .pend       (w_pend[g]),
        .pend_slot  (w_pslot[g]),
        .pend_addr  (w_paddr[g]),
        .gen        (w_gen[g])
      );
    end
  endgenerate

  sbpf_lru #(.NB(NUM_BUF), .BUF_W(BUF_W)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_en),
    .touch_id  (touch_id),
    .victim_id (victim_id),
    .victim_oh (victim_oh)
  );

  sbpf_req_arb #(
    .NB(NUM_BUF), .BUF_W(BUF_W), .SLOT_W(SLOT_W), .GEN_W(GEN_W), .LA_W(LA_W)
  ) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (w_pend),
    .pend_slot (w_pslot),
    .pend_addr (w_paddr),
    .pend_gen  (w_gen),
    .grant     (grant),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_tag   (req_tag)
  );
endmodule

// File: rtl/seqstream_prefetcher_chk.sv
module seqstream_prefetcher_chk #(
  parameter int NUM_BUF = 4,
  parameter int BUF_W   = 2,
  parameter int SLOT_W  = 2,
  parameter int TAG_W   = 6,
  parameter int LA_W    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               miss_valid,
  input logic               miss_done,
  input logic               miss_hit,
  input logic               req_valid,
  input logic               req_ready,
  input logic [LA_W-1:0]    req_addr,
  input logic [TAG_W-1:0]   req_tag,
  input logic [NUM_BUF-1:0] way_vld,
  input logic [NUM_BUF-1:0] victim_oh,
  input logic               stall
);
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (way_vld == '0) |-> !req_valid) else $error("idle request"); // R1

  AST_DONE_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    miss_done |-> miss_valid) else $error("done without lookup"); // R2

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_tag)))
    else $error("request changed under back-pressure"); // R3

  AST_TAG_BUF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (int'(req_tag[SLOT_W +: BUF_W]) < NUM_BUF)) else $error("tag buffer field"); // R4

  AST_HIT_IS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    miss_hit |-> miss_done) else $error("hit without done"); // R5

  AST_STALL_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !miss_done) else $error("done while stalled"); // R6

  AST_ONE_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(victim_oh) == 1) else $error("victim not unique"); // R8
endmodule

bind seqstream_prefetcher seqstream_prefetcher_chk #(
  .NUM_BUF(NUM_BUF), .BUF_W(BUF_W), .SLOT_W(SLOT_W), .TAG_W(TAG_W), .LA_W(LA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .miss_valid (miss_valid),
  .miss_done  (miss_done),
  .miss_hit   (miss_hit),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .req_tag    (req_tag),
  .way_vld    (way_vld),
  .victim_oh  (victim_oh),
  .stall      (stall)
);

// File: tb/seqstream_prefetcher_bench.sv
module seqstream_prefetcher_bench;
  localparam int CLK_P = 10;
  localparam int NB = 4, D = 4, GW = 2, BW = 2, SW = 2, TW = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        miss_valid;
  logic [31:0] miss_addr;
  logic        miss_done, miss_hit;
  logic [63:0] miss_data;
  logic        req_valid, req_ready;
  logic [31:0] req_addr;
  logic [TW-1:0] req_tag;
  logic        rsp_valid;
  logic [TW-1:0] rsp_tag;
  logic [63:0] rsp_data;

  always #(CLK_P/2) clk = ~clk;

  seqstream_prefetcher u_seqstream_prefetcher (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_done(miss_done), .miss_hit(miss_hit), .miss_data(miss_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data)
  );

  int nchk = 0, nfail = 0;
  // bench model of the streams
  bit          mvld [NB];
  logic [31:0] mhead [NB], mnext [NB], mbase [NB];
  int          mgen [NB], mrank [NB];
  // outstanding memory requests
  logic [31:0]   p_addr [128];
  logic [TW-1:0] p_tag [128];
  int pn = 0;
  bit ps_v = 0; logic [31:0] ps_a; logic [TW-1:0] ps_t;
  int lk_cnt = 0, nreq = 0, gviol = 0;
  bit last_hit = 0, hold = 0, rdy_rand = 0, guard = 0;
  string lk_lbl = "";

  function automatic logic [63:0] mk_data(logic [31:0] a);
    return {a ^ 32'h5A5A_0F0F, a};
  endfunction

  task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic touch(int b);
    for (int i = 0; i < NB; i++) if (i != b && mrank[i] < mrank[b]) mrank[i]++;
    mrank[b] = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  // Monitor: samples one time unit before each rising edge
  task automatic sample();
    int b, s, hb, v;
    if (req_valid && req_ready) begin
      b = int'(req_tag[SW +: BW]);
      s = int'(req_tag[SW-1:0]);
      p_addr[pn] = req_addr; p_tag[pn] = req_tag; pn++; nreq++;
      if (mvld[b] && req_tag[TW-1 -: GW] == GW'(mgen[b])) begin
        chk(req_addr == mnext[b], "R2", "prefetch address", 64'(req_addr), 64'(mnext[b]));
        chk(s == int'((req_addr - mbase[b] - 1) % D), "R4", "slot field",
            64'(s), 64'((req_addr - mbase[b] - 1) % D));
        mnext[b]++;
      end
    end
    if (ps_v)
      chk(req_valid && req_addr == ps_a && req_tag == ps_t, "R3", "request held",
          64'(req_addr), 64'(ps_a));
    ps_v = req_valid && !req_ready; ps_a = req_addr; ps_t = req_tag;
    if (miss_valid && miss_done) begin
      if (guard) gviol++;
      hb = -1;
      for (int i = NB-1; i >= 0; i--) if (mvld[i] && mhead[i] == miss_addr) hb = i;
      chk(miss_hit == (hb >= 0), (hb >= 0) ? "R5" : "R2", {"hit flag ", lk_lbl},
          64'(miss_hit), 64'(hb >= 0));
      last_hit = miss_hit;
      if (hb >= 0) begin
        chk(miss_data == mk_data(miss_addr), "R5", {"line data ", lk_lbl},
            miss_data, mk_data(miss_addr));
        mhead[hb]++;
        touch(hb);
      end else begin
        v = 0;
        for (int i = 0; i < NB; i++) if (mrank[i] == NB-1) v = i;
        mvld[v] = 1; mgen[v]++; mbase[v] = miss_addr;
        mhead[v] = miss_addr + 1; mnext[v] = miss_addr + 1;
        touch(v);
      end
      lk_cnt++;
    end
  endtask

  initial forever begin
    @(negedge clk); #(CLK_P/2 - 1);
    if (rst_n) sample();
  end

  // Next-level memory: random ready, out-of-order responses
  initial begin
    rsp_valid = 0; rsp_tag = '0; rsp_data = '0; req_ready = 1;
    forever begin
      @(posedge clk); #1;
      rsp_valid = 0;
      req_ready = rdy_rand ? (($urandom % 4) != 0) : 1'b1;
      if (!hold && pn > 0 && ($urandom % 3) != 0) begin
        int i;
        i = int'($urandom % pn);
        rsp_valid = 1; rsp_tag = p_tag[i]; rsp_data = mk_data(p_addr[i]);
        p_addr[i] = p_addr[pn-1]; p_tag[i] = p_tag[pn-1]; pn--;
      end
    end
  end

  task automatic lookup(logic [31:0] a, string lbl);
    int start;
    @(posedge clk); #1;
    lk_lbl = lbl; start = lk_cnt;
    miss_valid = 1; miss_addr = a;
    wait (lk_cnt != start);
    @(posedge clk); #1;
    miss_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] cur [6];
    int n0, c0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NB; i++) begin mvld[i] = 0; mgen[i] = 0; mrank[i] = NB-1-i; end
    rst_n = 0; miss_valid = 0; miss_addr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!req_valid, "R1", "no request after reset", 64'(req_valid), 0);
      chk(!miss_done, "R1", "no done after reset", 64'(miss_done), 0);
    end
    // first lookup misses; requests go back to back (responses held)
    hold = 1;
    lookup(32'h1000, "R1 first lookup");
    chk(!last_hit, "R1", "first lookup misses", 64'(last_hit), 0);
    n0 = nreq;
    repeat (D + 2) @(posedge clk);
    chk(nreq - n0 == D, "R3", "back-to-back requests", 64'(nreq - n0), 64'(D));
    chk(pn >= 2, "R3", "several outstanding", 64'(pn), 2);
    // head matches but data absent: no completion
    @(posedge clk); #1;
    c0 = lk_cnt; guard = 1; lk_lbl = "R6 stall";
    miss_valid = 1; miss_addr = 32'h1001;
    repeat (6) @(posedge clk);
    chk(gviol == 0 && lk_cnt == c0, "R6", "no done while data pending", 64'(gviol), 0);
    guard = 0; hold = 0;
    wait (lk_cnt != c0);
    @(posedge clk); #1; miss_valid = 0;
    chk(last_hit, "R6", "completes as hit after data", 64'(last_hit), 1);
    lookup(32'h1002, "R5 hit");
    lookup(32'h1003, "R5 hit");
    chk(last_hit, "R5", "sequential hit", 64'(last_hit), 1);
    // younger entry matches only: miss
    lookup(32'h1006, "R7 younger entry");
    chk(!last_hit, "R7", "non-head match is a miss", 64'(last_hit), 0);
    // LRU ordering
    lookup(32'h2000, "R8 alloc");
    lookup(32'h3000, "R8 alloc");
    lookup(32'h1004, "R8 touch");
    lookup(32'h4000, "R8 alloc");
    lookup(32'h1007, "R8 evicted stream");
    chk(!last_hit, "R8", "LRU stream replaced", 64'(last_hit), 0);
    lookup(32'h1005, "R8 kept stream");
    chk(last_hit, "R8", "recent stream kept", 64'(last_hit), 1);
    // stale responses after reuse of a buffer
    repeat (30) @(posedge clk);
    hold = 1;
    for (int i = 0; i < NB + 1; i++) lookup(32'h5000 + 32'(i) * 32'h1000, "R9 alloc");
    hold = 0;
    for (int i = 1; i <= D; i++) lookup(32'h9000 + 32'(i), "R9 reused buffer data");
    chk(last_hit, "R9", "reused buffer hit", 64'(last_hit), 1);
    // random interleaved streams
    rdy_rand = 1;
    for (int i = 0; i < 6; i++) cur[i] = 32'h0010_0000 * 32'(i + 1);
    for (int n = 0; n < 600; n++) begin
      int s;
      s = int'($urandom % 6);
      if (($urandom % 10) == 0) cur[s] = cur[s] + 32'($urandom % 8);
      lookup(cur[s], "R5 R8 random");
      cur[s]++;
    end
    repeat (20) @(posedge clk);
    finish_run();
  end
endmodule